// File: doc/BRIEF.md
# Modulo Address Stepper for a DMA Channel

This block forms the next transfer address for the source side and the destination side of a DMA channel. Each side holds a current address in a register. On every step the block adds a sign-extended 16-bit offset to that address. A 5-bit modulo code then decides how many low bits of the sum are kept. The bits above that region stay as they were in the current address, so a buffer aligned to its own power-of-two size is walked in a circle in either direction.

Code 0 turns wrapping off, and the whole 32-bit sum becomes the next address. Code n, for n from 1 to 31, confines the address to a region of 2^n bytes. Only bits below n may change, so the range runs from 2-byte buffers up to 2 GB buffers. The two sides have their own codes, offsets and strobes and never interact.

The combinational next address is visible on a port at all times. A load strobe writes a new base into the register, and an advance strobe commits the next address. If both strobes arrive in the same cycle, the load takes priority.

Top module: `modulo_addr_unit`

## Requirements
- R1: After reset, the registered address of both sides is 0.
- R2: With modulo code 0, the next address equals the current address plus the offset, sign-extended from 16 bits, modulo 2^32. A carry out of bit 31 is dropped.
- R3: With modulo code n (1 to 31), bits 31 down to n of the next address equal the same bits of the current address.
- R4: With modulo code n (1 to 31), bits n-1 down to 0 of the next address equal the same bits of the current address plus the sign-extended offset.
- R5: A negative offset wraps downward inside the region. For example, with code 4, current 0x1000_0000 and offset -1, the next address is 0x1000_000F.
- R6: A load strobe makes the registered address equal to the base input one clock edge later.
- R7: An advance strobe without a load makes the registered address equal to the next address seen before the edge. With neither strobe, the register holds its value.
- R8: When the load and advance strobes are high in the same cycle, the register takes the base value.
- R9: The source and destination sides are independent. The strobes, offset, code and base of one side have no effect on the other side's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_load_i | input | 1 | Load source base |
| src_base_i | input | 32 | Source base address |
| src_adv_i | input | 1 | Commit source next address |
| src_ofs_i | input | 16 | Signed source offset |
| src_code_i | input | 5 | Source modulo code (0 = no wrap) |
| src_addr_o | output | 32 | Registered source address |
| src_next_o | output | 32 | Next source address (combinational) |
| dst_load_i | input | 1 | Load destination base |
| dst_base_i | input | 32 | Destination base address |
| dst_adv_i | input | 1 | Commit destination next address |
| dst_ofs_i | input | 16 | Signed destination offset |
| dst_code_i | input | 5 | Destination modulo code (0 = no wrap) |
| dst_addr_o | output | 32 | Registered destination address |
| dst_next_o | output | 32 | Next destination address (combinational) |

## Verification
A base load and an advance can fall in the same cycle on one side. The bench raises both strobes together, using an offset and a code whose next address differs from the base. It then checks that the register holds the base after the edge and not the stepped value. Separately, every code from 0 to 31 is swept with random addresses and offsets of both signs. Each result is compared with an arithmetic model of the wrap, while the other side runs a different code at the same time.

// File: rtl/modulo_addr_pkg.sv
package modulo_addr_pkg;
  localparam int unsigned NUM_SIDES = 2;
  typedef enum logic [0:0] {SIDE_SRC = 1'b0, SIDE_DST = 1'b1} side_e;
endpackage

// File: rtl/mod_mask_gen.sv
module mod_mask_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CODE_W = 5
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] mask_o
);
  logic wrap_off;
  assign wrap_off = (code_i == '0);

  // bit i is free to change when wrapping is off or i < code
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    localparam logic [CODE_W:0] IDX = (CODE_W+1)'(i);
    assign mask_o[i] = wrap_off | ({1'b0, code_i} > IDX);
  end
endmodule

// File: rtl/addr_wrap_calc.sv
module addr_wrap_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;
  logic [ADDR_W-1:0] ofs_ext, sum;

  assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign sum     = cur_i + ofs_ext;
  assign next_o  = (cur_i & ~mask_i) | (sum & mask_i);
endmodule

// File: rtl/addr_track_reg.sv
module addr_track_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] next_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;   // load wins over advance
    else if (adv_i)  addr_o <= next_i;
  end
endmodule

// File: rtl/modulo_addr_lane.sv
module modulo_addr_lane #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] mask;

  mod_mask_gen #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_mask (
    .code_i (code_i),
    .mask_o (mask)
  );

  addr_wrap_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_calc (
    .cur_i  (addr_o),
    .ofs_i  (ofs_i),
    .mask_i (mask),
    .next_o (next_o)
  );

  addr_track_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .base_i (base_i),
    .adv_i  (adv_i),
    .next_i (next_o),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/modulo_addr_unit.sv
module modulo_addr_unit
  import modulo_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_load_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic              src_adv_i,
  input  logic [OFS_W-1:0]  src_ofs_i,
  input  logic [CODE_W-1:0] src_code_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] src_next_o,
  input  logic              dst_load_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic              dst_adv_i,
  input  logic [OFS_W-1:0]  dst_ofs_i,
  input  logic [CODE_W-1:0] dst_code_i,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [ADDR_W-1:0] dst_next_o
);
  logic [NUM_SIDES-1:0]             load, adv;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] base, addr, nxt;
  logic [NUM_SIDES-1:0][OFS_W-1:0]  ofs;
  logic [NUM_SIDES-1:0][CODE_W-1:0] code;

  assign load[SIDE_SRC] = src_load_i;
  assign load[SIDE_DST] = dst_load_i;
  assign adv[SIDE_SRC]  = src_adv_i;
  assign adv[SIDE_DST]  = dst_adv_i;
  assign base[SIDE_SRC] = src_base_i;
  assign base[SIDE_DST] = dst_base_i;
  assign ofs[SIDE_SRC]  = src_ofs_i;
  assign ofs[SIDE_DST]  = dst_ofs_i;
  assign code[SIDE_SRC] = src_code_i;
  assign code[SIDE_DST] = dst_code_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    modulo_addr_lane #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CODE_W(CODE_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[s]),
      .base_i (base[s]),
      .adv_i  (adv[s]),
      .ofs_i  (ofs[s]),
      .code_i (code[s]),
      .addr_o (addr[s]),
      .next_o (nxt[s])
    );
  end

  assign src_addr_o = addr[SIDE_SRC];
  assign src_next_o = nxt[SIDE_SRC];
  assign dst_addr_o = addr[SIDE_DST];
  assign dst_next_o = nxt[SIDE_DST];
endmodule

// File: rtl/modulo_addr_chk.sv
module modulo_addr_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 16,
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              adv_i,
  input logic [OFS_W-1:0]  ofs_i,
  input logic [CODE_W-1:0] code_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] full_sum, hi_diff, lo_diff;
  always_comb begin
    full_sum = addr_o + ADDR_W'($signed(ofs_i));
    hi_diff  = (next_o ^ addr_o) >> code_i;
    lo_diff  = (next_o ^ full_sum) << (ADDR_W - 32'(code_i));
  end

  p_full_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |-> (next_o == full_sum));
  p_upper_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0) |-> (hi_diff == '0));
  p_low_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0) |-> (lo_diff == '0));
  p_load_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(base_i)));
  p_adv_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (addr_o == $past(next_o)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(addr_o));
endmodule

bind modulo_addr_unit modulo_addr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CODE_W(CODE_W))
  u_chk_src (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(src_load_i), .base_i(src_base_i),
             .adv_i(src_adv_i), .ofs_i(src_ofs_i), .code_i(src_code_i),
             .addr_o(src_addr_o), .next_o(src_next_o)),
  u_chk_dst (.clk_i(clk_i), .rst_ni(rst_ni), .load_i(dst_load_i), .base_i(dst_base_i),
             .adv_i(dst_adv_i), .ofs_i(dst_ofs_i), .code_i(dst_code_i),
             .addr_o(dst_addr_o), .next_o(dst_next_o));

// File: tb/sim_modulo_addr_unit.sv
module sim_modulo_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_ld = 0, s_adv = 0, d_ld = 0, d_adv = 0;
  logic [31:0] s_base = 0, d_base = 0;
  logic [15:0] s_ofs = 0, d_ofs = 0;
  logic [4:0]  s_code = 0, d_code = 0;
  logic [31:0] s_addr, s_next, d_addr, d_next;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  modulo_addr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .src_load_i(s_ld), .src_base_i(s_base), .src_adv_i(s_adv), .src_ofs_i(s_ofs),
    .src_code_i(s_code), .src_addr_o(s_addr), .src_next_o(s_next),
    .dst_load_i(d_ld), .dst_base_i(d_base), .dst_adv_i(d_adv), .dst_ofs_i(d_ofs),
    .dst_code_i(d_code), .dst_addr_o(d_addr), .dst_next_o(d_next)
  );

  function automatic logic [31:0] model(logic [31:0] cur, logic [15:0] o, logic [4:0] c);
    logic [31:0] m, s;
    m = (c == 0) ? 32'hFFFF_FFFF : ((32'h1 << c) - 32'h1);
    s = cur + {{16{o[15]}}, o};
    return (cur & ~m) | (s & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobes applied on the falling edge, result read at the next falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
    s_ld = 0; s_adv = 0; d_ld = 0; d_adv = 0;
  endtask

  task automatic load_both(logic [31:0] sb, logic [31:0] db);
    s_base = sb; d_base = db; s_ld = 1; d_ld = 1;
    step();
  endtask

  initial begin
    logic [31:0] sexp, dexp, held;
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 src reset", s_addr, 32'h0);
    chk("R1 dst reset", d_addr, 32'h0);

    load_both(32'h1234_5678, 32'h9ABC_DEF0);
    chk("R6 src load", s_addr, 32'h1234_5678);
    chk("R6 dst load", d_addr, 32'h9ABC_DEF0);

    for (int c = 0; c < 32; c++) begin
      for (int t = 0; t < 4; t++) begin
        load_both($urandom, $urandom);
        s_code = 5'(c); d_code = 5'(31 - c);
        s_ofs = 16'($urandom); d_ofs = 16'($urandom);
        #1;
        sexp = model(s_addr, s_ofs, s_code);
        dexp = model(d_addr, d_ofs, d_code);
        if (c == 0) chk("R2 src next", s_next, sexp);
        else        chk("R3 R4 src next", s_next, sexp);
        chk("R9 dst next", d_next, dexp);
        s_adv = 1;
        step();
        chk("R7 src advance", s_addr, sexp);
        chk("R9 dst untouched by src advance", d_next, dexp);
      end
    end

    // negative offset wraps downward
    load_both(32'h1000_0000, 32'h0);
    s_code = 4; s_ofs = 16'hFFFF; #1;
    chk("R5 negative wrap", s_next, 32'h1000_000F);
    s_code = 8; s_ofs = 16'hFF00; #1;
    chk("R5 negative wrap large", s_next, 32'h1000_0000);

    // code 0 drops carry out of bit 31
    load_both(32'hFFFF_FFFF, 32'h0);
    s_code = 0; s_ofs = 16'h0001; #1;
    chk("R2 carry drop", s_next, 32'h0);
    // code 31 keeps bit 31
    load_both(32'hFFFF_FFFE, 32'h0);
    s_code = 31; s_ofs = 16'h0004; #1;
    chk("R3 code 31 top frozen", s_next, 32'h8000_0002);

    // hold with no strobes
    held = s_addr;
    step(); step();
    chk("R7 hold", s_addr, held);

    // load and advance together: load wins
    s_code = 3; s_ofs = 16'h0005; s_base = 32'hA5A5_0000;
    s_ld = 1; s_adv = 1;
    step();
    chk("R8 load priority", s_addr, 32'hA5A5_0000);

    // dst strobes do not disturb src
    held = s_addr;
    d_base = 32'h5555_AAAA; d_ld = 1;
    step();
    chk("R9 src stable on dst load", s_addr, held);
    chk("R6 dst load", d_addr, 32'h5555_AAAA);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule